// File: doc/BRIEF.md
# Multi-Block Flash Erase Sequencer

This block runs the erase-and-verify loop for a flash array made of several equal blocks. Software or a higher controller presents a bitmask of blocks to clear and pulses `start`. The sequencer then repeats rounds. In each round it raises a watchdog enable and holds the erase-mode control for a fixed pulse. It then switches to verify mode and reads back every byte of each still-selected block, comparing it with the erased value 0xFF.

A block whose bytes all read 0xFF is removed from the working mask, so the next erase pulse touches only the blocks that failed. The working mask is driven out on `eraseSel` and tells the array which blocks the erase pulse applies to. The run ends with `done` once the mask is empty. It ends with `error` if blocks still remain after the configured number of rounds. All waits are parameters counted in clock cycles, and the same holds for the block geometry and the round limit. Block `b` occupies addresses `b*BLOCK_SIZE` through `b*BLOCK_SIZE+BLOCK_SIZE-1`, and `BLOCK_SIZE` must be a power of two.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is held and after it releases, `busy`, `done`, `error`, `wdogEn`, `eraseMode`, `verifyMode`, `flashWe`, `flashRe` and `eraseSel` are all zero.
- R2: Each round raises `wdogEn` at least one cycle before `eraseMode`. `eraseMode` then stays high for exactly `PULSE_CYC` cycles with `wdogEn` high throughout, and `wdogEn` drops after `eraseMode` has cleared.
- R3: `eraseMode` and `verifyMode` are never high together. The first flash access of a round comes more than `SETTLE_CYC` cycles after `verifyMode` rises.
- R4: Checking a block starts with one write cycle (`flashWe`=1) of data 0xFF to the block's base address `index*BLOCK_SIZE`. Flash accesses occur only while `verifyMode` is high.
- R5: After that write, the sequencer reads (`flashRe`=1) every address of the block in ascending order, the first read coming more than `LATCH_CYC` cycles after the write. Read data is taken in the cycle after `flashRe`. Every block still set in `eraseSel` is checked in each round, and no other block is accessed.
- R6: A block whose reads all return 0xFF has its `eraseSel` bit cleared before the next round. A single non-0xFF byte, including the last byte of the block, keeps the bit set. During a run, bits are only ever cleared, never set.
- R7: When a round leaves `eraseSel` all zero, `verifyMode` drops, `busy` falls and `done` is set. The number of erase pulses equals the largest number of rounds any selected block needs.
- R8: If blocks remain after `MAX_ROUNDS` erase pulses, the run stops with `error` set and `done` clear, and `eraseSel` still shows exactly the failing blocks.
- R9: `start` is ignored while `busy` is high. `done` and `error` hold their value until the next accepted `start`, which clears both.
- R10: A `start` with an all-zero `blockMask` sets `done` on the next cycle without any erase pulse or flash access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| blockMask | input | NUM_BLOCKS | Blocks to erase, 1 = erase |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run erased every selected block |
| error | output | 1 | Last run exhausted the round limit |
| wdogEn | output | 1 | Watchdog enable around the erase pulse |
| eraseMode | output | 1 | Erase-mode control to the array |
| verifyMode | output | 1 | Erase-verify mode control to the array |
| eraseSel | output | NUM_BLOCKS | Working mask: blocks the erase pulse applies to |
| flashWe | output | 1 | Verify-address latch write strobe |
| flashRe | output | 1 | Byte read strobe |
| flashAddr | output | ADDR_W | Byte address for write or read |
| flashWdata | output | 8 | Write data, 0xFF during a latch write |
| flashRdata | input | 8 | Read data, valid the cycle after `flashRe` |

## Verification
A corrupted working mask or block index shows up within one round as a latch write to an unselected block base or a wrong final `eraseSel`. A skipped or repeated read address appears at the very next read as a break in the ascending address sequence. A round counter that is off changes the count of erase pulses. Because the bench array model leaves only the last byte of a block unerased on the round before it clears, a compare that stops early makes the block drop out one round too soon and shortens the pulse count.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WDOG_ON,
    ST_ERASE,
    ST_ERASE_OFF,
    ST_SETTLE,
    ST_SCAN,
    ST_DUMMY,
    ST_LATCH,
    ST_READ,
    ST_CHECK,
    ST_BLK_END,
    ST_ROUND_END
  } seq_state_e;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic loadMask;
    logic roundInit;
    logic roundInc;
    logic tmrClr;
    logic blkClr;
    logic blkInc;
    logic offClr;
    logic offInc;
    logic failClr;
    logic sampleRd;
    logic dropBlk;
  } seq_strobe_t;

endpackage

// File: rtl/erase_seq_dpath.sv
module erase_seq_dpath
  import erase_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BLOCK_SIZE = 256,
  parameter int PULSE_CYC  = 2500000,
  parameter int SETTLE_CYC = 1000,
  parameter int LATCH_CYC  = 500,
  parameter int MAX_ROUNDS = 3000,
  localparam int ADDR_W    = $clog2(NUM_BLOCKS * BLOCK_SIZE)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seq_strobe_t           strobe,
  input  logic [NUM_BLOCKS-1:0] blockMask,
  input  logic [7:0]            flashRdata,
  output logic [NUM_BLOCKS-1:0] eraseSel,
  output logic [ADDR_W-1:0]     flashAddr,
  output logic                  maskZero,
  output logic                  blkSel,
  output logic                  lastBlk,
  output logic                  lastOff,
  output logic                  pulseEnd,
  output logic                  settleEnd,
  output logic                  latchEnd,
  output logic                  failSeen,
  output logic                  roundLimit
);

  localparam int BLK_W   = $clog2(NUM_BLOCKS);
  localparam int OFF_W   = $clog2(BLOCK_SIZE);
  localparam int LONGEST = (PULSE_CYC > SETTLE_CYC)
                         ? ((PULSE_CYC > LATCH_CYC) ? PULSE_CYC : LATCH_CYC)
                         : ((SETTLE_CYC > LATCH_CYC) ? SETTLE_CYC : LATCH_CYC);
  localparam int TMR_W   = $clog2(LONGEST + 1);
  localparam int RND_W   = $clog2(MAX_ROUNDS + 1);

  localparam logic [TMR_W-1:0] PULSE_LAST  = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] SETTLE_LAST = TMR_W'(SETTLE_CYC - 1);
  localparam logic [TMR_W-1:0] LATCH_LAST  = TMR_W'(LATCH_CYC - 1);
  localparam logic [BLK_W-1:0] BLK_LAST    = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [OFF_W-1:0] OFF_LAST    = OFF_W'(BLOCK_SIZE - 1);
  localparam logic [RND_W-1:0] RND_LIMIT   = RND_W'(MAX_ROUNDS);

  logic [NUM_BLOCKS-1:0] maskQ;
  logic [BLK_W-1:0]      blkIdx;
  logic [OFF_W-1:0]      offQ;
  logic [TMR_W-1:0]      tmrQ;
  logic [RND_W-1:0]      roundQ;
  logic                  failQ;

  // Working mask: one update path per block
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_mask
    always_ff @(posedge clk) begin
      if (!rstN)
        maskQ[b] <= 1'b0;
      else if (strobe.loadMask)
        maskQ[b] <= blockMask[b];
      else if (strobe.dropBlk && (blkIdx == BLK_W'(b)))
        maskQ[b] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blkIdx <= '0;
      offQ   <= '0;
      tmrQ   <= '0;
      roundQ <= '0;
      failQ  <= 1'b0;
    end else begin
      if (strobe.blkClr)      blkIdx <= '0;
      else if (strobe.blkInc) blkIdx <= blkIdx + 1'b1;

      if (strobe.offClr)      offQ <= '0;
      else if (strobe.offInc) offQ <= offQ + 1'b1;

      if (strobe.tmrClr) tmrQ <= '0;
      else               tmrQ <= tmrQ + 1'b1;

      if (strobe.roundInit)     roundQ <= RND_W'(1);
      else if (strobe.roundInc) roundQ <= roundQ + 1'b1;

      if (strobe.failClr)       failQ <= 1'b0;
      else if (strobe.sampleRd) failQ <= failQ | (flashRdata != ERASED_BYTE);
    end
  end

  assign eraseSel   = maskQ;
  assign flashAddr  = ADDR_W'(blkIdx) * ADDR_W'(BLOCK_SIZE) + ADDR_W'(offQ);
  assign maskZero   = (maskQ == '0);
  assign blkSel     = maskQ[blkIdx];
  assign lastBlk    = (blkIdx == BLK_LAST);
  assign lastOff    = (offQ == OFF_LAST);
  assign pulseEnd   = (tmrQ == PULSE_LAST);
  assign settleEnd  = (tmrQ == SETTLE_LAST);
  assign latchEnd   = (tmrQ == LATCH_LAST);
  assign failSeen   = failQ;
  assign roundLimit = (roundQ >= RND_LIMIT);

  // R6: between loads the mask only loses bits
  assert_mask_only_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadMask |=> ((maskQ & ~$past(maskQ)) == '0));

  // R6: a block is dropped only if selected and no mismatch was seen
  assert_drop_clean_block_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropBlk |-> (!failQ && blkSel));

  // R8: round counter never passes the limit
  assert_round_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    roundQ <= RND_LIMIT);

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        reqAny,
  input  logic        maskZero,
  input  logic        blkSel,
  input  logic        lastBlk,
  input  logic        lastOff,
  input  logic        pulseEnd,
  input  logic        settleEnd,
  input  logic        latchEnd,
  input  logic        failSeen,
  input  logic        roundLimit,
  output seq_strobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        error,
  output logic        wdogEn,
  output logic        eraseMode,
  output logic        verifyMode,
  output logic        flashWe,
  output logic        flashRe,
  output logic [7:0]  flashWdata
);

  seq_state_e stateQ, stateD;
  logic doneQ, doneD, errQ, errD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      doneQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= doneD;
      errQ   <= errD;
    end
  end

  always_comb begin
    stateD = stateQ;
    doneD  = doneQ;
    errD   = errQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: begin
        if (start) begin
          errD = 1'b0;
          if (reqAny) begin
            doneD            = 1'b0;
            strobe.loadMask  = 1'b1;
            strobe.roundInit = 1'b1;
            stateD           = ST_WDOG_ON;
          end else begin
            doneD = 1'b1;
          end
        end
      end
      ST_WDOG_ON: begin
        strobe.tmrClr = 1'b1;
        stateD        = ST_ERASE;
      end
      ST_ERASE: begin
        if (pulseEnd) stateD = ST_ERASE_OFF;
      end
      ST_ERASE_OFF: begin
        strobe.tmrClr = 1'b1;
        strobe.blkClr = 1'b1;
        stateD        = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settleEnd) stateD = ST_SCAN;
      end
      ST_SCAN: begin
        if (blkSel) begin
          strobe.offClr  = 1'b1;
          strobe.failClr = 1'b1;
          stateD         = ST_DUMMY;
        end else if (lastBlk) begin
          stateD = ST_ROUND_END;
        end else begin
          strobe.blkInc = 1'b1;
        end
      end
      ST_DUMMY: begin
        strobe.tmrClr = 1'b1;
        stateD        = ST_LATCH;
      end
      ST_LATCH: begin
        if (latchEnd) stateD = ST_READ;
      end
      ST_READ: begin
        stateD = ST_CHECK;
      end
      ST_CHECK: begin
        strobe.sampleRd = 1'b1;
        if (lastOff) begin
          stateD = ST_BLK_END;
        end else begin
          strobe.offInc = 1'b1;
          stateD        = ST_READ;
        end
      end
      ST_BLK_END: begin
        strobe.dropBlk = !failSeen;
        if (lastBlk) begin
          stateD = ST_ROUND_END;
        end else begin
          strobe.blkInc = 1'b1;
          stateD        = ST_SCAN;
        end
      end
      ST_ROUND_END: begin
        if (maskZero) begin
          doneD  = 1'b1;
          stateD = ST_IDLE;
        end else if (roundLimit) begin
          errD   = 1'b1;
          stateD = ST_IDLE;
        end else begin
          strobe.roundInc = 1'b1;
          stateD          = ST_WDOG_ON;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy       = (stateQ != ST_IDLE);
  assign done       = doneQ;
  assign error      = errQ;
  assign wdogEn     = (stateQ == ST_WDOG_ON) || (stateQ == ST_ERASE) ||
                      (stateQ == ST_ERASE_OFF);
  assign eraseMode  = (stateQ == ST_ERASE);
  assign verifyMode = (stateQ == ST_SETTLE) || (stateQ == ST_SCAN) ||
                      (stateQ == ST_DUMMY) || (stateQ == ST_LATCH) ||
                      (stateQ == ST_READ) || (stateQ == ST_CHECK) ||
                      (stateQ == ST_BLK_END);
  assign flashWe    = (stateQ == ST_DUMMY);
  assign flashRe    = (stateQ == ST_READ);
  assign flashWdata = flashWe ? ERASED_BYTE : 8'h00;

  // R2: watchdog enable covers the whole erase pulse
  assert_wdog_covers_erase_R2: assert property (@(posedge clk) disable iff (!rstN)
    eraseMode |-> wdogEn);

  // R2: watchdog enable is already up the cycle before erase starts
  assert_wdog_leads_erase_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eraseMode) |-> $past(wdogEn));

  // R3: erase and verify modes never overlap
  assert_modes_exclusive_R3: assert property (@(posedge clk) disable iff (!rstN)
    !(eraseMode && verifyMode));

  // R4: flash accesses only in verify mode
  assert_access_in_verify_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flashWe || flashRe) |-> verifyMode);

  // R7: completion flags are exclusive and only shown when idle
  assert_flags_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> (!busy && !(done && error)));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import erase_seq_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BLOCK_SIZE = 256,
  parameter int PULSE_CYC  = 2500000,
  parameter int SETTLE_CYC = 1000,
  parameter int LATCH_CYC  = 500,
  parameter int MAX_ROUNDS = 3000,
  localparam int ADDR_W    = $clog2(NUM_BLOCKS * BLOCK_SIZE)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [NUM_BLOCKS-1:0] blockMask,
  output logic                  busy,
  output logic                  done,
  output logic                  error,
  output logic                  wdogEn,
  output logic                  eraseMode,
  output logic                  verifyMode,
  output logic [NUM_BLOCKS-1:0] eraseSel,
  output logic                  flashWe,
  output logic                  flashRe,
  output logic [ADDR_W-1:0]     flashAddr,
  output logic [7:0]            flashWdata,
  input  logic [7:0]            flashRdata
);

  seq_strobe_t strobe;
  logic maskZero, blkSel, lastBlk, lastOff;
  logic pulseEnd, settleEnd, latchEnd, failSeen, roundLimit;

  erase_seq_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .reqAny     (|blockMask),
    .maskZero   (maskZero),
    .blkSel     (blkSel),
    .lastBlk    (lastBlk),
    .lastOff    (lastOff),
    .pulseEnd   (pulseEnd),
    .settleEnd  (settleEnd),
    .latchEnd   (latchEnd),
    .failSeen   (failSeen),
    .roundLimit (roundLimit),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .wdogEn     (wdogEn),
    .eraseMode  (eraseMode),
    .verifyMode (verifyMode),
    .flashWe    (flashWe),
    .flashRe    (flashRe),
    .flashWdata (flashWdata)
  );

  erase_seq_dpath #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLOCK_SIZE (BLOCK_SIZE),
    .PULSE_CYC  (PULSE_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .LATCH_CYC  (LATCH_CYC),
    .MAX_ROUNDS (MAX_ROUNDS)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .blockMask  (blockMask),
    .flashRdata (flashRdata),
    .eraseSel   (eraseSel),
    .flashAddr  (flashAddr),
    .maskZero   (maskZero),
    .blkSel     (blkSel),
    .lastBlk    (lastBlk),
    .lastOff    (lastOff),
    .pulseEnd   (pulseEnd),
    .settleEnd  (settleEnd),
    .latchEnd   (latchEnd),
    .failSeen   (failSeen),
    .roundLimit (roundLimit)
  );

endmodule

// File: tb/flash_erase_seq_tb_top.sv
`timescale 1ns/1ps
module flash_erase_seq_tb_top;

  localparam int NB     = 4;
  localparam int BS     = 4;
  localparam int PULSE  = 5;
  localparam int SETTLE = 3;
  localparam int LATCH  = 2;
  localparam int MAXR   = 4;
  localparam int AW     = $clog2(NB * BS);
  localparam int NVEC   = 6;

  // mask, per-block rounds needed (4 bits per block, block 0 lowest),
  // expected error flag, expected final eraseSel, expected pulse count
  localparam logic [3:0]  V_MASK [NVEC] = '{4'b0001, 4'b1111, 4'b0101, 4'b1010, 4'b1000, 4'b0110};
  localparam logic [15:0] V_NEED [NVEC] = '{16'h1111, 16'h1321, 16'h9492, 16'h2151, 16'h4111, 16'h1661};
  localparam logic        V_ERR  [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic [3:0]  V_SEL  [NVEC] = '{4'b0000, 4'b0000, 4'b0000, 4'b0010, 4'b0000, 4'b0110};
  localparam int          V_RND  [NVEC] = '{1, 3, 4, 4, 4, 4};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [NB-1:0] blockMask = '0;
  logic busy, done, error, wdogEn, eraseMode, verifyMode, flashWe, flashRe;
  logic [NB-1:0] eraseSel;
  logic [AW-1:0] flashAddr;
  logic [7:0] flashWdata;
  logic [7:0] flashRdata = 8'h00;

  always #2 clk = ~clk;

  flash_erase_seq #(
    .NUM_BLOCKS (NB),
    .BLOCK_SIZE (BS),
    .PULSE_CYC  (PULSE),
    .SETTLE_CYC (SETTLE),
    .LATCH_CYC  (LATCH),
    .MAX_ROUNDS (MAXR)
  ) dut_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .blockMask  (blockMask),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .wdogEn     (wdogEn),
    .eraseMode  (eraseMode),
    .verifyMode (verifyMode),
    .eraseSel   (eraseSel),
    .flashWe    (flashWe),
    .flashRe    (flashRe),
    .flashAddr  (flashAddr),
    .flashWdata (flashWdata),
    .flashRdata (flashRdata)
  );

  // ---------------- flash array model and protocol monitor ----------------
  logic [7:0] mem [NB*BS];
  int  needLeft [NB];
  logic loadReq = 1'b0;
  logic [15:0] needCfg = '0;
  int cyc = 0, eLen = 0, pulses = 0, monErr = 0, writes = 0, reads = 0;
  int expAcc = 0, vRise = 0, wrCyc = 0, expRd = 0;
  bit firstAcc = 0, prevErase = 0, prevVerify = 0;

  always @(posedge clk) if (flashRe) flashRdata <= mem[flashAddr];

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (loadReq) begin
      for (int b = 0; b < NB; b++) begin
        needLeft[b] = int'(needCfg[4*b +: 4]);
        for (int i = 0; i < BS; i++) mem[b*BS + i] = 8'h00;
      end
      eLen = 0; pulses = 0; monErr = 0; writes = 0; reads = 0; expAcc = 0;
      firstAcc = 0;
    end else begin
      if (eraseMode) begin
        if (!prevErase) expAcc = expAcc + $countones(eraseSel);
        eLen = eLen + 1;
        if (!wdogEn) monErr = monErr + 1;
      end
      if (prevErase && !eraseMode) begin
        pulses = pulses + 1;
        if (eLen != PULSE) monErr = monErr + 1;
        if (!wdogEn) monErr = monErr + 1;
        eLen = 0;
        for (int b = 0; b < NB; b++) begin
          if (eraseSel[b] && needLeft[b] > 0) begin
            needLeft[b] = needLeft[b] - 1;
            if (needLeft[b] == 0)
              for (int i = 0; i < BS; i++) mem[b*BS + i] = 8'hFF;
            else if (needLeft[b] == 1)
              for (int i = 0; i < BS - 1; i++) mem[b*BS + i] = 8'hFF;
          end
        end
      end
      if (verifyMode && !prevVerify) begin
        vRise = cyc;
        firstAcc = 1;
      end
      if ((flashWe || flashRe) && !verifyMode) monErr = monErr + 1;
      if (flashWe) begin
        if (firstAcc && (cyc - vRise) <= SETTLE) monErr = monErr + 1;
        firstAcc = 0;
        if ((int'(flashAddr) % BS) != 0 || !eraseSel[int'(flashAddr) / BS] ||
            flashWdata != 8'hFF) monErr = monErr + 1;
        expRd = int'(flashAddr);
        wrCyc = cyc;
        writes = writes + 1;
      end
      if (flashRe) begin
        if (int'(flashAddr) != expRd || (cyc - wrCyc) <= LATCH) monErr = monErr + 1;
        expRd = expRd + 1;
        reads = reads + 1;
      end
    end
    prevErase = eraseMode;
    prevVerify = verifyMode;
  end

  // ---------------- checking ----------------
  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input logic [NB-1:0] m, input logic [15:0] need);
    @(posedge clk); #1;
    needCfg = need;
    loadReq = 1'b1;
    @(posedge clk); #1;
    loadReq = 1'b0;
    start = 1'b1;
    blockMask = m;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    do begin
      @(negedge clk); #0.5;
      n++;
    end while (busy && n < 20000);
    check(!busy, "R7 run finished", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state, during and after reset
    repeat (3) @(negedge clk);
    check({busy, done, error, wdogEn, eraseMode, verifyMode, flashWe, flashRe} == 8'h00 &&
          eraseSel == '0, "R1 outputs in reset", int'(busy), 0);
    @(posedge clk); #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    check({busy, done, error, wdogEn, eraseMode, verifyMode, flashWe, flashRe} == 8'h00 &&
          eraseSel == '0, "R1 outputs after reset", int'(done), 0);

    // Vector table: R2..R8
    for (int v = 0; v < NVEC; v++) begin
      launch(V_MASK[v], V_NEED[v]);
      waitIdle();
      check(done == !V_ERR[v] && error == V_ERR[v], "R7/R8 completion flags",
            int'({done, error}), int'({!V_ERR[v], V_ERR[v]}));
      check(eraseSel == V_SEL[v], "R6/R8 final eraseSel", int'(eraseSel), int'(V_SEL[v]));
      check(pulses == V_RND[v], "R7 erase pulse count", pulses, V_RND[v]);
      check(monErr == 0, "R2/R3/R4/R5 protocol timing", monErr, 0);
      check(writes == expAcc && reads == expAcc * BS, "R5 reads cover selected blocks",
            reads, expAcc * BS);
    end

    // R10: empty mask finishes at once with no erase
    @(posedge clk); #1;
    loadReq = 1'b1;
    needCfg = 16'h1111;
    @(posedge clk); #1;
    loadReq = 1'b0;
    start = 1'b1;
    blockMask = '0;
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(done && !busy && !error, "R10 zero mask done", int'({done, busy, error}), 4);
    repeat (20) @(negedge clk);
    check(pulses == 0 && writes == 0 && reads == 0, "R10 no erase or access",
          pulses + writes + reads, 0);

    // R9: start while busy is ignored
    launch(4'b0001, 16'h1112);
    repeat (10) @(negedge clk);
    @(posedge clk); #1;
    start = 1'b1;
    blockMask = 4'b1111;
    @(posedge clk); #1;
    start = 1'b0;
    waitIdle();
    check(done && eraseSel == '0 && pulses == 2 && writes == 2,
          "R9 mid-run start ignored", writes, 2);
    repeat (20) @(negedge clk);
    check(done && !error, "R9 done held while idle", int'(done), 1);

    // R9: next accepted start clears done
    launch(4'b0001, 16'h1111);
    @(negedge clk);
    check(!done && !error && busy, "R9 start clears flags", int'({done, error, busy}), 1);
    waitIdle();
    check(done, "R9 done after rerun", int'(done), 1);

    // R8 then R9: error held, then cleared by next start
    launch(4'b0001, 16'h1119);
    waitIdle();
    check(error && !done && eraseSel == 4'b0001, "R8 error with failing block",
          int'(eraseSel), 1);
    repeat (10) @(negedge clk);
    check(error, "R9 error held while idle", int'(error), 1);
    launch(4'b0001, 16'h1111);
    @(negedge clk);
    check(!error && busy, "R9 start clears error", int'(error), 0);
    waitIdle();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule